// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a fast reference clock into the sampling rate that a serial controller needs. Software programs one 32-bit control word that holds an enable flag, a divide-by-16 prescaler select and a 12-bit divisor written as the wanted ratio minus one. The block then emits a one-cycle `tick` strobe at the programmed rate and a square-wave `baud_clk` for routing elsewhere. Receivers that take the strobe oversample by 16, so the tick rate is sixteen times the line rate.

A write that changes settings while the generator is running is held back until the current period has run out, so a period is never cut short. A restart flag in the same word brings the counter and prescaler back to their starting point at once. This flag reads back as set for one cycle and then clears. Clearing the enable stops the generator at once and forces both outputs low.

Top module: `baud_gen`

## Requirements
- R1: Control word layout: bit 0 selects the divide-by-16 prescaler, bits 12:1 hold the divisor, bit 16 is enable and bit 17 is restart. A read returns the last written prescaler, divisor and enable fields, with bit 17 as described in R8 and every other bit zero.
- R2: With the prescaler off and divisor D, ticks come every D+1 clock cycles. The first tick follows an enabling write from the disabled state by D+1 cycles, counted from the write edge.
- R3: With the prescaler off and divisor 0, `tick` is high on every cycle while enabled.
- R4: With the prescaler on and divisor D, both the tick period and the first-tick delay are 16*(D+1) cycles.
- R5: While enable is clear, `tick` and `baud_clk` stay low.
- R6: `baud_clk` inverts at each tick, giving a square wave at half the tick rate.
- R7: A write that keeps enable set while the generator runs (restart clear) does not change the period in progress. The new settings take over at the next tick.
- R8: A write with restart set applies its settings at once and restarts the count from the write edge. Bit 17 reads 1 in the cycle after the write and 0 in the cycle after that.
- R9: After reset, `tick` and `baud_clk` are low and the control word reads zero.
- R10: The full divisor 4095 without the prescaler gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| tick | output | 1 | One-cycle strobe at the programmed rate |
| baud_clk | output | 1 | Square wave that inverts at each tick |

## Verification
Divisors 0, 1, 6 and 4095 with the prescaler off, and 0 and 3 with it on, are each started from the disabled state. For every setting both the first-tick delay and the next period are measured. This separates an off-by-one in the reload, a prescaler that is skipped or applied twice, and a counter that is truncated at its top value. Two mid-period writes cover the remaining timing cases. A deferred write must keep the old period once, and a restart write must move the next tick, so writes that apply too early or too late are both caught.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
    localparam int DIV_W   = 12;
    localparam int PRE_W   = 4;
    localparam int REG_W   = 32;
    localparam int PRE_BIT = 0;
    localparam int DIV_LSB = 1;
    localparam int EN_BIT  = 16;
    localparam int RST_BIT = 17;

    typedef struct packed {
        logic             en;
        logic             pre;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/bgen_regif.sv
module bgen_regif
    import bgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             term,
    output cfg_t             cfg_q_o,
    output cfg_t             cfg_nxt_o,
    output logic             load,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        cfg_t act;
        cfg_t pend;
        logic pend_v;
        cfg_t shadow;
        logic clr;
    } rif_t;

    rif_t s_d, s_q;
    cfg_t w;
    logic w_rst;

    always_comb begin
        w.en  = wdata[EN_BIT];
        w.pre = wdata[PRE_BIT];
        w.div = wdata[DIV_LSB +: DIV_W];
        w_rst = wdata[RST_BIT];

        s_d     = s_q;
        s_d.clr = 1'b0;
        load    = 1'b0;

        if (wr && (!s_q.act.en || !w.en || w_rst)) begin
            s_d.act    = w;
            s_d.pend_v = 1'b0;
            load       = 1'b1;
        end else begin
            if (wr) begin
                s_d.pend   = w;
                s_d.pend_v = 1'b1;
            end
            if (term && (wr || s_q.pend_v)) begin
                s_d.act    = wr ? w : s_q.pend;
                s_d.pend_v = 1'b0;
            end
        end

        if (wr) begin
            s_d.shadow = w;
            s_d.clr    = w_rst;
        end

        rdata                     = '0;
        rdata[PRE_BIT]            = s_q.shadow.pre;
        rdata[DIV_LSB +: DIV_W]   = s_q.shadow.div;
        rdata[EN_BIT]             = s_q.shadow.en;
        rdata[RST_BIT]            = s_q.clr;

        cfg_q_o   = s_q.act;
        cfg_nxt_o = s_d.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
    parameter int PRE_W = bgen_pkg::PRE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel,
    input  logic load,
    output logic ce
);
    logic [PRE_W-1:0] pre_d, pre_q;

    assign ce = !sel || (pre_q == {PRE_W{1'b1}});

    always_comb begin
        if (load || !en || !sel) pre_d = '0;
        else                     pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/bgen_counter.sv
module bgen_counter #(
    parameter int DIV_W = bgen_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ce,
    input  logic             load,
    input  logic [DIV_W-1:0] nxt_div,
    output logic             term,
    output logic             tick,
    output logic             baud,
    output logic [DIV_W-1:0] cnt_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
        logic             baud;
    } cnt_t;

    cnt_t s_d, s_q;

    assign term = en && ce && (s_q.cnt == '0);

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (load || !en) begin
            s_d.cnt  = nxt_div;
            s_d.baud = 1'b0;
        end else if (ce) begin
            if (s_q.cnt == '0) begin
                s_d.tick = 1'b1;
                s_d.baud = ~s_q.baud;
                s_d.cnt  = nxt_div;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick  = s_q.tick;
    assign baud  = s_q.baud;
    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import bgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             tick,
    output logic             baud_clk
);
    cfg_t             cfg_q, cfg_nxt;
    logic             load, term, ce;
    logic [DIV_W-1:0] cnt_val;

    bgen_regif u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .term     (term),
        .cfg_q_o  (cfg_q),
        .cfg_nxt_o(cfg_nxt),
        .load     (load),
        .rdata    (reg_rdata)
    );

    bgen_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_q.en),
        .sel  (cfg_q.pre),
        .load (load),
        .ce   (ce)
    );

    bgen_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_q.en),
        .ce     (ce),
        .load   (load),
        .nxt_div(cfg_nxt.div),
        .term   (term),
        .tick   (tick),
        .baud   (baud_clk),
        .cnt_o  (cnt_val)
    );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
    import bgen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_rdata,
    input logic             tick,
    input logic             baud_clk,
    input logic             cfg_en,
    input logic             cfg_pre,
    input logic [DIV_W-1:0] cfg_div,
    input logic [DIV_W-1:0] cnt_val
);
    // R5
    tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !tick);

    // R6
    baud_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (baud_clk != $past(baud_clk)));

    // R8
    clr_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[RST_BIT] && !reg_wr) |=> !reg_rdata[RST_BIT]);

    // R3
    div0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_pre && cfg_div == '0 && !reg_wr) |=> tick);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_val <= cfg_div);
endmodule

bind baud_gen baud_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rdata(reg_rdata),
    .tick     (tick),
    .baud_clk (baud_clk),
    .cfg_en   (cfg_q.en),
    .cfg_pre  (cfg_q.pre),
    .cfg_div  (cfg_q.div),
    .cnt_val  (cnt_val)
);

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick, baud_clk;

    int checks = 0;
    int errors = 0;

    always #HALF clk = ~clk;

    baud_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .tick     (tick),
        .baud_clk (baud_clk)
    );

    // {prescale, divisor, expected period}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV][3] = '{
        '{32'd0, 32'd0,    32'd1},    // R3
        '{32'd0, 32'd1,    32'd2},    // R2
        '{32'd0, 32'd6,    32'd7},    // R2
        '{32'd0, 32'd4095, 32'd4096}, // R10
        '{32'd1, 32'd0,    32'd16},   // R4
        '{32'd1, 32'd3,    32'd64}    // R4
    };

    function automatic logic [31:0] word(input logic en, input logic pre,
                                         input logic [11:0] div, input logic rst);
        logic [31:0] v;
        v = '0;
        v[0] = pre;
        v[12:1] = div;
        v[16] = en;
        v[17] = rst;
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_tick(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!tick && k < 5000);
    endtask

    initial begin
        #(2 * HALF * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k, k2;
        logic b1;
        logic bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9
        chk(tick == 0 && baud_clk == 0 && reg_rdata == 0, "R9", reg_rdata, 0);

        // R1 readback of fields, reserved bits zero
        wr_reg(32'hFFFD_FFFF);
        chk(reg_rdata == 32'h0001_1FFF, "R1", reg_rdata, 32'h0001_1FFF);
        wr_reg(32'h0);
        chk(reg_rdata == 32'h0, "R1", reg_rdata, 0);

        // table walk: first-tick delay, period, baud inversion
        for (int i = 0; i < NV; i++) begin
            wr_reg(32'h0);
            wr_reg(word(1'b1, VEC[i][0][0], VEC[i][1][11:0], 1'b0));
            wait_tick(k);
            chk(k == int'(VEC[i][2]), "R2/R3/R4/R10 first tick", k, VEC[i][2]);
            b1 = baud_clk;
            wait_tick(k2);
            chk(k2 == int'(VEC[i][2]), "R2/R3/R4/R10 period", k2, VEC[i][2]);
            // R6
            chk(baud_clk != b1, "R6", baud_clk, !b1);
        end

        // R3 tick stays high every cycle with divisor 0
        wr_reg(32'h0);
        wr_reg(word(1'b1, 1'b0, 12'd0, 1'b0));
        @(negedge clk);
        bad = 1'b0;
        for (int j = 0; j < 20; j++) begin
            if (!tick) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R3 continuous", bad, 0);

        // R5 disable holds outputs low
        wr_reg(32'h0);
        bad = 1'b0;
        for (int j = 0; j < 40; j++) begin
            if (tick || baud_clk) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R5", bad, 0);

        // R7 deferred write while running
        wr_reg(word(1'b1, 1'b0, 12'd9, 1'b0));
        wait_tick(k);
        chk(k == 10, "R2 setup", k, 10);
        @(negedge clk);
        @(negedge clk);
        wr_reg(word(1'b1, 1'b0, 12'd2, 1'b0));
        wait_tick(k);
        chk(k + 3 == 10, "R7 current period kept", k + 3, 10);
        wait_tick(k);
        chk(k == 3, "R7 new period", k, 3);

        // R8 restart mid-period
        wr_reg(32'h0);
        wr_reg(word(1'b1, 1'b0, 12'd9, 1'b0));
        wait_tick(k);
        @(negedge clk);
        @(negedge clk);
        wr_reg(word(1'b1, 1'b0, 12'd9, 1'b1));
        chk(reg_rdata[17] == 1'b1, "R8 flag set", reg_rdata[17], 1);
        @(negedge clk);
        chk(reg_rdata[17] == 1'b0, "R8 flag clears", reg_rdata[17], 0);
        wait_tick(k);
        chk(k + 1 == 10, "R8 restart delay", k + 1, 10);

        wr_reg(32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule